// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

This block steps through a chain of transfer descriptors kept in a dedicated list memory for a single DMA channel. Software supplies a list base address and pulses start. The walker then reads each descriptor as four consecutive words through a simple one-outstanding memory read port. It checks whether the descriptor belongs to the current list generation. Each data descriptor becomes one command to an external data mover, and the walker waits for that command to complete before it fetches the next descriptor.

Link descriptors redirect the walk to another address and can flip the walker's cycle state. This lets software reuse the same memory for successive generations of descriptors. Software marks each generation by the value of a per-descriptor change bit. Completion of a descriptor can raise a local done interrupt, a remote done output, or both. A memory or mover error stops the walk and raises an abort interrupt instead.

Top module: `ll_dma_walker`

## Requirements
- R1: A start pulse while idle loads the pointer from `list_base`, sets the cycle state to 1, and makes `busy` high on the next cycle. A start pulse while `busy` is high has no effect on the walk.
- R2: A descriptor at word address p occupies p (control), p+1 (byte count), p+2 (source address) and p+3 (destination address). These four words are read in that order. A new read is requested only after the previous read has returned `mem_rd_valid`.
- R3: Control word bit 0 is the change bit, bit 1 the toggle flag, bit 2 the link marker, bit 3 the local interrupt enable and bit 4 the remote interrupt enable. Bits 31..5 have no effect. A descriptor whose change bit differs from the cycle state issues no command, sets no interrupt, and returns the walker to idle with `busy` low.
- R4: An owned data descriptor (bit 2 = 0) produces exactly one command, carrying its source, destination and 32-bit byte count. `cmd_valid` and the fields stay stable until `cmd_ready`. No memory read occurs while a command is pending or outstanding.
- R5: After a good completion, the next descriptor is fetched at p+4. An owned link descriptor issues no command. The next descriptor is fetched from the address held in its word 2, and the cycle state inverts only when the link's bit 1 is set.
- R6: A good completion of a descriptor with bit 3 set raises `irq_local`. With bit 4 set, it raises `irq_remote`. Both are levels that remain high until cleared.
- R7: A read returning `mem_rd_err` or a completion with `done_err` stops the walk (`busy` low) and raises the level `irq_abort`. That descriptor sets neither done output.
- R8: `clr_local`, `clr_remote` and `clr_abort` are one-cycle write-one-to-clear pulses. Each clears only its own flag on the next cycle. A set in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| list_base | input | AW | Word address of the first descriptor |
| busy | output | 1 | High while a walk is in progress |
| mem_rd_en | output | 1 | Read request to list memory |
| mem_rd_addr | output | AW | Word address of the read |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | DW | Read data |
| mem_rd_err | input | 1 | Error on the returned read |
| cmd_valid | output | 1 | Mover command valid |
| cmd_ready | input | 1 | Mover accepts command |
| cmd_src | output | DW | Source address |
| cmd_dst | output | DW | Destination address |
| cmd_len | output | DW | Byte count |
| done_valid | input | 1 | Mover completion pulse |
| done_err | input | 1 | Completion carries an error |
| irq_local | output | 1 | Local done interrupt (level) |
| irq_remote | output | 1 | Remote done output (level) |
| irq_abort | output | 1 | Abort interrupt (level) |
| clr_local | input | 1 | Clear pulse for irq_local |
| clr_remote | input | 1 | Clear pulse for irq_remote |
| clr_abort | input | 1 | Clear pulse for irq_abort |

## Verification
Several rules are checked on every cycle by properties:
- one read in flight at a time;
- command stability under backpressure;
- mutual exclusion of reads and commands;
- silence when idle;
- stickiness of the interrupt levels and the effect of their clear pulses.

Other behaviour only shows up in scenarios, where the bench compares the read address sequence and the command stream against a behavioural walk of its own copy of the list memory:
- the ownership decision;
- link redirection with and without a toggle;
- generation refill;
- ignored reserved bits;
- which flags each completion raises;
- truncation of the walk after a read or completion error.

// File: rtl/ll_dma_walker.sv
module ll_dma_walker #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] list_base,
  output logic          busy,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_valid,
  input  logic [DW-1:0] mem_rd_data,
  input  logic          mem_rd_err,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [DW-1:0] cmd_src,
  output logic [DW-1:0] cmd_dst,
  output logic [DW-1:0] cmd_len,
  input  logic          done_valid,
  input  logic          done_err,
  output logic          irq_local,
  output logic          irq_remote,
  output logic          irq_abort,
  input  logic          clr_local,
  input  logic          clr_remote,
  input  logic          clr_abort
);
  localparam int ELEM_WORDS = 4;
  localparam int IW = $clog2(ELEM_WORDS);
  localparam int CW = 5;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_ISSUE, S_WAIT, S_LINK} state_t;

  state_t        state;
  logic [AW-1:0] ptr;
  logic [IW-1:0] idx;
  logic          pend;
  logic          cyc;
  logic [CW-1:0] ctl;
  logic [DW-1:0] len_q, src_q, dst_q;

  wire rd_back  = (state == S_FETCH) && pend && mem_rd_valid;
  wire rd_bad   = rd_back && mem_rd_err;
  wire cmp_ok   = (state == S_WAIT) && done_valid && !done_err;
  wire cmp_bad  = (state == S_WAIT) && done_valid && done_err;

  assign busy        = (state != S_IDLE);
  assign mem_rd_en   = (state == S_FETCH) && !pend;
  assign mem_rd_addr = ptr + AW'(idx);
  assign cmd_valid   = (state == S_ISSUE);
  assign cmd_src     = src_q;
  assign cmd_dst     = dst_q;
  assign cmd_len     = len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ptr   <= '0;
      idx   <= '0;
      pend  <= 1'b0;
      cyc   <= 1'b1;
      ctl   <= '0;
      len_q <= '0;
      src_q <= '0;
      dst_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          ptr   <= list_base;
          cyc   <= 1'b1;
          idx   <= '0;
          pend  <= 1'b0;
          state <= S_FETCH;
        end
        S_FETCH: begin
          if (mem_rd_en) pend <= 1'b1;
          if (rd_back) begin
            pend <= 1'b0;
            if (rd_bad) state <= S_IDLE;
            else begin
              case (idx)
                IW'(0):  ctl   <= mem_rd_data[CW-1:0];
                IW'(1):  len_q <= mem_rd_data;
                IW'(2):  src_q <= mem_rd_data;
                default: dst_q <= mem_rd_data;
              endcase
              if (idx == IW'(ELEM_WORDS-1)) state <= S_CHECK;
              else idx <= idx + 1'b1;
            end
          end
        end
        S_CHECK: begin
          idx <= '0;
          if (ctl[0] != cyc) state <= S_IDLE;
          else if (ctl[2])   state <= S_LINK;
          else               state <= S_ISSUE;
        end
        S_LINK: begin
          ptr <= src_q[AW-1:0];
          if (ctl[1]) cyc <= ~cyc;
          state <= S_FETCH;
        end
        S_ISSUE: if (cmd_ready) state <= S_WAIT;
        S_WAIT: begin
          if (cmp_bad) state <= S_IDLE;
          else if (cmp_ok) begin
            ptr   <= ptr + AW'(ELEM_WORDS);
            state <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_local  <= 1'b0;
      irq_remote <= 1'b0;
      irq_abort  <= 1'b0;
    end else begin
      irq_local  <= (irq_local  & ~clr_local)  | (cmp_ok & ctl[3]);
      irq_remote <= (irq_remote & ~clr_remote) | (cmp_ok & ctl[4]);
      irq_abort  <= (irq_abort  & ~clr_abort)  | rd_bad | cmp_bad;
    end
  end
endmodule

// File: rtl/ll_dma_walker_chk.sv
module ll_dma_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        mem_rd_en,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [31:0] cmd_src,
  input logic [31:0] cmd_dst,
  input logic [31:0] cmd_len,
  input logic        done_valid,
  input logic        irq_local,
  input logic        irq_remote,
  input logic        irq_abort,
  input logic        clr_local,
  input logic        clr_remote,
  input logic        clr_abort
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) start && !busy |=> busy); // R1
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_en |=> !mem_rd_en); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_rd_en && !cmd_valid); // R3
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_src) && $stable(cmd_dst) && $stable(cmd_len)); // R4
  AST_NO_READ_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd_en && cmd_valid)); // R4
  AST_LOCAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) irq_local && !clr_local |=> irq_local); // R6
  AST_REMOTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) irq_remote && !clr_remote |=> irq_remote); // R6
  AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) irq_abort && !clr_abort |=> irq_abort); // R7
  AST_CLR_LOCAL: assert property (@(posedge clk) disable iff (!rst_n) clr_local && !done_valid |=> !irq_local); // R8
  AST_CLR_REMOTE: assert property (@(posedge clk) disable iff (!rst_n) clr_remote && !done_valid |=> !irq_remote); // R8
endmodule

bind ll_dma_walker ll_dma_walker_chk u_chk (.*);

// File: tb/ll_dma_walker_tb.sv
`timescale 1ns/1ps
module ll_dma_walker_tb;
  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] list_base = '0;
  logic busy, mem_rd_en, mem_rd_valid = 0, mem_rd_err = 0;
  logic [15:0] mem_rd_addr;
  logic [31:0] mem_rd_data = '0;
  logic cmd_valid, cmd_ready = 0;
  logic [31:0] cmd_src, cmd_dst, cmd_len;
  logic done_valid = 0, done_err = 0;
  logic irq_local, irq_remote, irq_abort;
  logic clr_local = 0, clr_remote = 0, clr_abort = 0;

  always #10 clk = ~clk;

  ll_dma_walker u_dut (.*);

  logic [31:0]  mem [0:255];
  int           exp_rd[$];
  logic [127:0] exp_cmd[$];
  bit exp_loc = 0, exp_rem = 0, exp_abt = 0, mon_en = 0, finished = 0;
  int rd_cnt = 0, cmd_cnt = 0, rd_err_at = -1, dn_err_at = -1;
  int nchk = 0, nerr = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  // behavioural walk of the bench memory
  task automatic build(input int base);
    int p = base;
    bit c = 1'b1;
    int nrd = 0, ncmd = 0;
    logic [31:0] w;
    exp_rd.delete();
    exp_cmd.delete();
    for (int e = 0; e < 32; e++) begin
      for (int k = 0; k < 4; k++) begin
        exp_rd.push_back(p + k);
        if (nrd == rd_err_at) return;
        nrd++;
      end
      w = mem[p];
      if (w[0] != c) return;
      if (w[2]) begin
        if (w[1]) c = ~c;
        p = int'(mem[p+2] & 32'hFF);
      end else begin
        exp_cmd.push_back({w, mem[p+1], mem[p+2], mem[p+3]});
        if (ncmd == dn_err_at) return;
        ncmd++;
        p = p + 4;
      end
    end
  endtask

  // memory responder
  initial forever begin
    int a;
    @(negedge clk);
    mem_rd_valid = 0;
    mem_rd_err = 0;
    if (mem_rd_en) begin
      a = int'(mem_rd_addr);
      if (exp_rd.size() == 0) chk(0, "R2 unexpected read", a, 0);
      else begin
        chk(a == exp_rd[0], "R2 read address", a, exp_rd[0]);
        void'(exp_rd.pop_front());
      end
      @(negedge clk);
      mem_rd_valid = 1;
      mem_rd_data = mem[a & 255];
      mem_rd_err = (rd_cnt == rd_err_at);
      if (mem_rd_err) exp_abt = 1;
      rd_cnt++;
    end
  end

  // mover model
  initial forever begin
    logic [127:0] ec;
    @(negedge clk);
    cmd_ready = 0;
    done_valid = 0;
    done_err = 0;
    if (cmd_valid) begin
      if (exp_cmd.size() == 0) begin
        chk(0, "R4 unexpected command", cmd_src, 0);
        ec = '0;
      end else begin
        ec = exp_cmd.pop_front();
        chk(cmd_len == ec[95:64], "R4 cmd length", cmd_len, ec[95:64]);
        chk(cmd_src == ec[63:32], "R4 cmd source", cmd_src, ec[63:32]);
        chk(cmd_dst == ec[31:0], "R4 cmd destination", cmd_dst, ec[31:0]);
      end
      repeat (cmd_cnt % 3) begin
        @(negedge clk);
        chk(cmd_valid && cmd_src == ec[63:32], "R4 held under backpressure", cmd_src, ec[63:32]);
      end
      cmd_ready = 1;
      @(negedge clk);
      cmd_ready = 0;
      repeat (2) @(negedge clk);
      done_valid = 1;
      done_err = (cmd_cnt == dn_err_at);
      if (done_err) exp_abt = 1;
      else begin
        if (ec[99]) exp_loc = 1;
        if (ec[100]) exp_rem = 1;
      end
      cmd_cnt++;
    end
  end

  // per-cycle monitor
  initial forever begin
    @(posedge clk);
    #5;
    if (mon_en) begin
      chk(irq_local == exp_loc, "R6 irq_local", irq_local, exp_loc);
      chk(irq_remote == exp_rem, "R6 irq_remote", irq_remote, exp_rem);
      chk(irq_abort == exp_abt, "R7 irq_abort", irq_abort, exp_abt);
      chk(!(mem_rd_en && cmd_valid), "R4 read during command", mem_rd_en, 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic kick(input int base);
    @(negedge clk);
    rd_cnt = 0;
    cmd_cnt = 0;
    build(base);
    list_base = 16'(base);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R1 busy after start", busy, 1);
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    chk(busy == 0, {tag, " walker idle"}, busy, 0);
    chk(exp_rd.size() == 0, {tag, " reads outstanding"}, exp_rd.size(), 0);
    chk(exp_cmd.size() == 0, {tag, " commands outstanding"}, exp_cmd.size(), 0);
  endtask

  task automatic pulse_clr(input int which);
    @(negedge clk);
    if (which == 0) begin clr_local = 1; exp_loc = 0; end
    if (which == 1) begin clr_remote = 1; exp_rem = 0; end
    if (which == 2) begin clr_abort = 1; exp_abt = 0; end
    @(negedge clk);
    clr_local = 0;
    clr_remote = 0;
    clr_abort = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    mon_en = 1;
    chk(busy == 0 && !mem_rd_en && !cmd_valid, "R1 reset idle", busy, 0);
    chk(!irq_local && !irq_remote && !irq_abort, "R6 reset flags", {irq_local, irq_remote, irq_abort}, 0);

    // generation 1 at 16: three data, toggling link back to 16 -> mismatch stop (R3, R5)
    mem[16] = 32'h1; mem[17] = 100;          mem[18] = 32'h1000; mem[19] = 32'h2000;
    mem[20] = 32'h9; mem[21] = 1;            mem[22] = 32'h1100; mem[23] = 32'h2100;
    mem[24] = 32'h19; mem[25] = 32'hFFFF_FFFF; mem[26] = 32'h1200; mem[27] = 32'h2200;
    mem[28] = 32'h7; mem[29] = 0;            mem[30] = 16;       mem[31] = 0;
    kick(16);
    repeat (6) @(negedge clk);
    list_base = 16'd200;
    start = 1;                                // R1 start while busy is ignored
    @(negedge clk);
    start = 0;
    wait_idle("R3 R5 gen1");
    chk(irq_local && irq_remote, "R6 both done flags", {irq_local, irq_remote}, 2'b11);

    pulse_clr(0);
    @(negedge clk);
    chk(!irq_local && irq_remote, "R8 local clear only", {irq_local, irq_remote}, 2'b01);
    pulse_clr(1);
    @(negedge clk);
    chk(!irq_remote, "R8 remote clear", irq_remote, 0);

    // refill with change 0: start resets cycle to 1, so nothing is owned (R3)
    mem[16] = 32'h0; mem[20] = 32'h8; mem[24] = 32'h18;
    kick(16);
    wait_idle("R3 refill not owned");
    chk(!irq_local && !irq_remote, "R3 no flags on mismatch", {irq_local, irq_remote}, 0);

    // link without toggle, then with toggle into change-0 elements, reserved bits set (R5, R3)
    mem[40] = 32'h5;  mem[41] = 0; mem[42] = 64;  mem[43] = 0;
    mem[64] = 32'h9;  mem[65] = 8; mem[66] = 32'hA000; mem[67] = 32'hB000;
    mem[68] = 32'h7;  mem[69] = 0; mem[70] = 100; mem[71] = 0;
    mem[100] = 32'h10; mem[101] = 4; mem[102] = 32'hC000; mem[103] = 32'hD000;
    mem[104] = 32'h0000_0F00; mem[105] = 2; mem[106] = 32'hC100; mem[107] = 32'hD100;
    mem[108] = 32'h1;  mem[109] = 3; mem[110] = 32'hC200; mem[111] = 32'hD200;
    kick(40);
    wait_idle("R5 link chain");
    chk(irq_local && irq_remote, "R5 flags from both generations", {irq_local, irq_remote}, 2'b11);
    pulse_clr(0);
    pulse_clr(1);

    // read error on the link element's second word (R7)
    rd_err_at = 5;
    kick(64);
    wait_idle("R7 read error");
    chk(irq_abort == 1, "R7 abort on read error", irq_abort, 1);
    chk(irq_local == 1, "R7 earlier element still done", irq_local, 1);
    pulse_clr(2);
    @(negedge clk);
    chk(!irq_abort && irq_local, "R8 abort clear only", {irq_abort, irq_local}, 2'b01);
    pulse_clr(0);
    rd_err_at = -1;

    // completion error on first command: abort, no local flag (R7)
    dn_err_at = 0;
    kick(64);
    wait_idle("R7 completion error");
    chk(irq_abort == 1 && irq_local == 0, "R7 abort replaces done", {irq_abort, irq_local}, 2'b10);
    pulse_clr(2);
    dn_err_at = -1;

    repeat (5) @(negedge clk);
    summary();
  end
endmodule